// File: doc/BRIEF.md
# Subsequent Violation Record Scanner

This block keeps one sticky flag for each requester ID. A flag records that the requester caused an access violation that could not be logged, because the single error-report slot already held a first violation. Software cannot see these later violations in the error report. It reads them back through one 32-bit read-to-scan status word.

The flags are grouped into windows of 16 contiguous bits. Each read strobe starts a circular search at the stored window index and stops at the first window that holds any set flag. The response carries that window's flags, its index and a found bit. The block then clears that window in the same clock edge. If no window holds a flag, the response reports "nothing found" and the index is left where it was. A summary output stays high while any flag is pending, so software can poll a single bit before it drains the record.

The requester count is a parameter. With the default of 64 requesters there are 4 windows. The search only visits implemented windows, so after the last window it continues at window zero.

Top module: `viol_record_scan`

## Requirements
- R1: After reset all flags are clear, the stored window index is 0, `pending_any` is low, `rd_valid` is low and `rd_data` is zero.
- R2: A flag is set only by a cycle with `viol_valid` high and `first_logged` high. A violation strobe while `first_logged` is low changes no flag.
- R3: Bit j of window i holds the flag of requester i*16+j. A returned window appears in `rd_data[15:0]`, with bit j at position j.
- R4: `rd_valid` is high exactly in the cycle after a cycle with `rd_stb` high, and `rd_data` is updated only at that edge.
- R5: A read searches windows forward from the stored index, starting with that index itself. It returns the first window with any set flag and reports that window's number in `rd_data[27:16]`. That number becomes the new stored index.
- R6: The search wraps from the last implemented window (NUM_WIN-1) to window 0, and every reported index is below NUM_WIN.
- R7: A read that finds a window clears every flag of that window and leaves all other windows untouched.
- R8: A read that finds no set flag returns 0 in bit 31 and in bits [15:0], and returns the unchanged stored index in bits [27:16].
- R9: Bit 31 of `rd_data` is 1 exactly when a window was found, and bits [30:28] always read 0.
- R10: `pending_any` is high in every cycle in which at least one flag is set. It rises in the cycle after the setting strobe and falls in the cycle after the read that clears the last flag.
- R11: If a violation sets a flag in the same cycle a read clears that flag's window, the flag stays set. The same read does not report it.
- R12: Repeated violations from one requester leave a single set bit, and the flag holds until a read clears its window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| viol_valid | input | 1 | A violation is reported this cycle |
| viol_req_id | input | RID_W | Requester ID of the reported violation |
| first_logged | input | 1 | The error report already holds a first violation |
| rd_stb | input | 1 | Read strobe of the status word; starts a scan |
| rd_data | output | 32 | Status word: found bit [31], index [27:16], window flags [15:0] |
| rd_valid | output | 1 | `rd_data` holds the response to the previous cycle's strobe |
| pending_any | output | 1 | At least one subsequent-violation flag is set |

## Verification
A flag that is wrongly set or lost shows up at the next read. That read returns a window field or found bit that differs from the bench's record, and `pending_any` is wrong from the cycle after the faulty edge. A corrupted stored index shows in the first read after it, either as a wrong index field or as the wrong window when more than one window is occupied. The tests therefore occupy several windows at once so the search order can be seen. A clear that hits the wrong window only becomes visible when that window is read again, so every scenario drains the record until a read comes back empty.

// File: rtl/viol_record_pkg.sv
package viol_record_pkg;

   // Status word layout
   localparam int RD_W      = 32;
   localparam int WIN_W     = 16;
   localparam int IDX_W     = 12;
   localparam int IDX_LSB   = 16;
   localparam int FOUND_BIT = 31;

   typedef struct packed {
      logic             found;
      logic [2:0]       rsvd;
      logic [IDX_W-1:0] idx;
      logic [WIN_W-1:0] flags;
   } status_word_t;

   function automatic logic [RD_W-1:0] pack_status(
      input logic             found,
      input logic [IDX_W-1:0] idx,
      input logic [WIN_W-1:0] flags);
      status_word_t w;
      w.found = found;
      w.rsvd  = 3'b000;
      w.idx   = idx;
      w.flags = found ? flags : '0;
      return w;
   endfunction

endpackage

// File: rtl/viol_flag_bank.sv
module viol_flag_bank #(
   parameter int NUM_REQ = 64,
   parameter int WIN_W   = 16,
   parameter int NUM_WIN = 4,
   parameter int RID_W   = 6,
   parameter int IDX_W   = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          set_en,
   input  logic [RID_W-1:0]              set_id,
   input  logic                          clr_en,
   input  logic [IDX_W-1:0]              clr_win,
   output logic [NUM_WIN-1:0][WIN_W-1:0] win_flags,
   output logic [NUM_WIN-1:0]            win_nz
);

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic clr_here;
      assign clr_here = clr_en && (clr_win == IDX_W'(w));

      for (genvar b = 0; b < WIN_W; b++) begin : g_bit
         localparam int ID = w * WIN_W + b;
         if (ID < NUM_REQ) begin : g_impl
            logic q;
            logic set_here;
            assign set_here = set_en && (set_id == RID_W'(ID));
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)         q <= 1'b0;
               else if (set_here)  q <= 1'b1;   // set beats clear
               else if (clr_here)  q <= 1'b0;
            end
            assign win_flags[w][b] = q;
         end else begin : g_absent
            assign win_flags[w][b] = 1'b0;
         end
      end

      assign win_nz[w] = |win_flags[w];
   end

endmodule

// File: rtl/viol_win_search.sv
module viol_win_search #(
   parameter int NUM_WIN = 4,
   parameter int WIN_W   = 16,
   parameter int IDX_W   = 12
) (
   input  logic [IDX_W-1:0]              start_idx,
   input  logic [NUM_WIN-1:0]            win_nz,
   input  logic [NUM_WIN-1:0][WIN_W-1:0] win_flags,
   output logic                          hit,
   output logic [IDX_W-1:0]              hit_idx,
   output logic [WIN_W-1:0]              hit_flags
);

   localparam logic [IDX_W:0] NWIN_X = (IDX_W+1)'(NUM_WIN);

   logic [NUM_WIN-1:0][IDX_W-1:0] cand;

   // Candidate window number for each search step, wrapped to implemented windows
   for (genvar i = 0; i < NUM_WIN; i++) begin : g_cand
      logic [IDX_W:0] sum;
      assign sum     = {1'b0, start_idx} + (IDX_W+1)'(i);
      assign cand[i] = (sum >= NWIN_X) ? IDX_W'(sum - NWIN_X) : sum[IDX_W-1:0];
   end

   // Lowest step with a non-empty window wins
   always_comb begin
      hit     = 1'b0;
      hit_idx = start_idx;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         for (int w = 0; w < NUM_WIN; w++) begin
            if (cand[i] == IDX_W'(w) && win_nz[w]) begin
               hit     = 1'b1;
               hit_idx = cand[i];
            end
         end
      end
   end

   always_comb begin
      hit_flags = '0;
      for (int w = 0; w < NUM_WIN; w++) begin
         if (hit_idx == IDX_W'(w)) hit_flags = win_flags[w];
      end
   end

endmodule

// File: rtl/viol_rd_port.sv
module viol_rd_port
   import viol_record_pkg::*;
#(
   parameter int RESP_W = RD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic              hit,
   input  logic [IDX_W-1:0]  hit_idx,
   input  logic [WIN_W-1:0]  hit_flags,
   output logic [IDX_W-1:0]  cur_idx,
   output logic [RESP_W-1:0] rd_data,
   output logic              rd_valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_idx  <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_stb;
         if (rd_stb) begin
            if (hit) cur_idx <= hit_idx;
            rd_data <= RESP_W'(pack_status(hit, hit ? hit_idx : cur_idx, hit_flags));
         end
      end
   end

endmodule

// File: rtl/viol_record_scan.sv
module viol_record_scan
   import viol_record_pkg::*;
#(
   parameter int NUM_REQ = 64,
   parameter int RID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             viol_valid,
   input  logic [RID_W-1:0] viol_req_id,
   input  logic             first_logged,
   input  logic             rd_stb,
   output logic [31:0]      rd_data,
   output logic             rd_valid,
   output logic             pending_any
);

   localparam int NUM_WIN = (NUM_REQ + WIN_W - 1) / WIN_W;

   if (NUM_REQ < 1) begin : g_chk_req
      $error("viol_record_scan: NUM_REQ must be at least 1");
   end
   if (NUM_WIN > (1 << IDX_W)) begin : g_chk_idx
      $error("viol_record_scan: too many windows for the index field");
   end
   if (RID_W < $clog2(NUM_REQ)) begin : g_chk_rid
      $error("viol_record_scan: RID_W too narrow for NUM_REQ");
   end

   logic [NUM_WIN-1:0][WIN_W-1:0] win_flags;
   logic [NUM_WIN-1:0]            win_nz;
   logic                          hit;
   logic [IDX_W-1:0]              hit_idx;
   logic [WIN_W-1:0]              hit_flags;
   logic [IDX_W-1:0]              cur_idx;

   viol_flag_bank #(
      .NUM_REQ (NUM_REQ),
      .WIN_W   (WIN_W),
      .NUM_WIN (NUM_WIN),
      .RID_W   (RID_W),
      .IDX_W   (IDX_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (viol_valid && first_logged),
      .set_id    (viol_req_id),
      .clr_en    (rd_stb && hit),
      .clr_win   (hit_idx),
      .win_flags (win_flags),
      .win_nz    (win_nz)
   );

   viol_win_search #(
      .NUM_WIN (NUM_WIN),
      .WIN_W   (WIN_W),
      .IDX_W   (IDX_W)
   ) u_search (
      .start_idx (cur_idx),
      .win_nz    (win_nz),
      .win_flags (win_flags),
      .hit       (hit),
      .hit_idx   (hit_idx),
      .hit_flags (hit_flags)
   );

   viol_rd_port #(
      .RESP_W (32)
   ) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_stb    (rd_stb),
      .hit       (hit),
      .hit_idx   (hit_idx),
      .hit_flags (hit_flags),
      .cur_idx   (cur_idx),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid)
   );

   assign pending_any = |win_nz;

endmodule

// File: rtl/viol_record_scan_chk.sv
module viol_record_scan_chk #(
   parameter int NUM_REQ = 64,
   parameter int RID_W   = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             viol_valid,
   input logic [RID_W-1:0] viol_req_id,
   input logic             first_logged,
   input logic             rd_stb,
   input logic [31:0]      rd_data,
   input logic             rd_valid,
   input logic             pending_any
);

   localparam int NUM_WIN = (NUM_REQ + 15) / 16;

   assert_resp_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> rd_valid);
   assert_no_stray_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> !rd_valid);
   assert_empty_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_data[31]) |-> (rd_data[15:0] == 16'h0));
   assert_hit_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_data[31]) |-> (rd_data[15:0] != 16'h0));
   assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_data[30:28] == 3'b000));
   assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (32'(rd_data[27:16]) < NUM_WIN));
   assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_valid && first_logged) |=> pending_any);
   assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_any && !rd_stb) |=> pending_any);
   assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending_any && !(viol_valid && first_logged)) |=> !pending_any);
   assert_found_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && pending_any) |=> rd_data[31]);
   assert_empty_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !pending_any) |=> !rd_data[31]);

endmodule

bind viol_record_scan viol_record_scan_chk #(
   .NUM_REQ (NUM_REQ),
   .RID_W   (RID_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .viol_valid   (viol_valid),
   .viol_req_id  (viol_req_id),
   .first_logged (first_logged),
   .rd_stb       (rd_stb),
   .rd_data      (rd_data),
   .rd_valid     (rd_valid),
   .pending_any  (pending_any)
);

// File: tb/viol_record_scan_bench.sv
`timescale 1ns/1ps
module viol_record_scan_bench;

   localparam int NREQ = 64;
   localparam int NWIN = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        viol_valid = 1'b0;
   logic [5:0]  viol_req_id = '0;
   logic        first_logged = 1'b0;
   logic        rd_stb = 1'b0;
   logic [31:0] rd_data;
   logic        rd_valid;
   logic        pending_any;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   logic [NREQ-1:0] m_flags = '0;
   int              m_idx   = 0;

   always #4 clk = ~clk;

   viol_record_scan #(.NUM_REQ(NREQ)) u_viol_record_scan (
      .clk          (clk),
      .rst_n        (rst_n),
      .viol_valid   (viol_valid),
      .viol_req_id  (viol_req_id),
      .first_logged (first_logged),
      .rd_stb       (rd_stb),
      .rd_data      (rd_data),
      .rd_valid     (rd_valid),
      .pending_any  (pending_any)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Model of one read: circular search, clear found window
   function automatic logic [31:0] model_read();
      for (int i = 0; i < NWIN; i++) begin
         int w = (m_idx + i) % NWIN;
         logic [15:0] f = m_flags[w*16 +: 16];
         if (f != 16'h0) begin
            m_idx = w;
            m_flags[w*16 +: 16] = 16'h0;
            return {1'b1, 3'b000, 12'(w), f};
         end
      end
      return {1'b0, 3'b000, 12'(m_idx), 16'h0};
   endfunction

   task automatic viol(input int id, input bit logged);
      @(negedge clk);
      viol_valid   = 1'b1;
      viol_req_id  = 6'(id);
      first_logged = logged;
      @(negedge clk);
      viol_valid   = 1'b0;
      first_logged = 1'b0;
      if (logged) m_flags[id] = 1'b1;
   endtask

   // Read; optional same-cycle violation (id >= 0)
   task automatic rd(input string req, input int vid = -1);
      logic [31:0] exp;
      @(negedge clk);
      rd_stb = 1'b1;
      exp = model_read();
      if (vid >= 0) begin
         viol_valid = 1'b1; viol_req_id = 6'(vid); first_logged = 1'b1;
      end
      @(negedge clk);
      rd_stb = 1'b0;
      viol_valid = 1'b0; first_logged = 1'b0;
      if (vid >= 0) m_flags[vid] = 1'b1;
      check({31'h0, rd_valid}, 32'h1, "R4");
      check(rd_data, exp, req);
      check({31'h0, pending_any}, {31'h0, |m_flags}, "R10");
   endtask

   task automatic t_reset();
      check(rd_data, 32'h0, "R1");
      check({30'h0, rd_valid, pending_any}, 32'h0, "R1");
      rd("R1");
   endtask

   task automatic t_ignore_unlogged();
      viol(9, 1'b0);
      check({31'h0, pending_any}, 32'h0, "R2");
      rd("R2");
   endtask

   task automatic t_mapping();
      viol(5, 1'b1);
      viol(20, 1'b1);
      check({31'h0, pending_any}, 32'h1, "R10");
      rd("R3");            // window 0, bit 5
      rd("R3");            // window 1, bit 4
      rd("R8");            // empty, index stays 1
      @(negedge clk);
      check({31'h0, rd_valid}, 32'h0, "R4");
   endtask

   task automatic t_order_wrap();
      viol(3, 1'b1);       // window 0
      viol(50, 1'b1);      // window 3
      rd("R5");            // from index 1: window 3 first
      rd("R6");            // wraps to window 0
      rd("R8");
   endtask

   task automatic t_clear_one();
      viol(17, 1'b1);
      viol(33, 1'b1);
      viol(34, 1'b1);
      rd("R7");            // from 0: window 1 only
      check({31'h0, pending_any}, 32'h1, "R7");
      rd("R7");            // window 2, bits 1 and 2
      rd("R8");
   endtask

   task automatic t_set_wins();
      viol(40, 1'b1);
      rd("R11", 41);       // returns bit 8 of window 2, sets bit 9 same cycle
      rd("R11");           // bit 9 survived the clear
      rd("R8");
   endtask

   task automatic t_sticky();
      viol(63, 1'b1);
      viol(63, 1'b1);
      viol(63, 1'b1);
      viol(63, 1'b0);
      rd("R12");
      rd("R9");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ignore_unlogged();
      t_mapping();
      t_order_wrap();
      t_clear_one();
      t_set_wins();
      t_sticky();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 20000);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule